// File: doc/BRIEF.md
# Dual-Lane 16-bit Multiply-Accumulate Datapath

This block holds two multiply-accumulate lanes, each with a private 40-bit accumulator. On every clock a lane may be issued. It picks the upper or lower 16-bit half of each of its two 32-bit source words, multiplies the two halves, and writes, adds or subtracts the product into its accumulator. Both lanes can be issued together, each with its own operation and half selection. A lane that is not issued keeps its value.

By default both operands are signed 1.15 fractions, and the product is doubled before it is used. Lane 1 has an extra mixed-sign mode: the first operand is signed, the second is unsigned, and the product is used as is. Sums and differences wrap silently in two's complement over the 40-bit width. The low 32 bits of each accumulator are always visible on the output ports. A synchronous clear zeroes both accumulators.

Top module: `dual_mac`

## Requirements
- R1: For each operand, the select bit picks the source bits [31:16] when it is 1 and bits [15:0] when it is 0. The four selections are independent.
- R2: In the default mode the product is the signed 16x16 product shifted left by one bit. For example, 0x3456 times 0x4567 added to zero reads 0x1C607934.
- R3: When `l1_mixed` is 1, lane 1 treats its first operand as signed and its second as unsigned, with no shift. For example, 0x5678 times 0xC789 assigned reads 0x43658E38. Lane 0 is always in the default mode.
- R4: The operation code is 2'b00 hold, 2'b01 assign (acc = p), 2'b10 add (acc = acc + p) and 2'b11 subtract (acc = acc - p). Code 2'b00 leaves the accumulator unchanged even when the lane is valid.
- R5: The product is sign-extended to 40 bits. The add and subtract wrap modulo 2^40 with no saturation, and the read ports show bits [31:0]. For example, zero minus 0x43658E38 reads 0xBC9A71C8.
- R6: Both lanes may be issued in the same cycle and act independently. A lane whose valid is low keeps its accumulator.
- R7: `clr` high at a rising edge zeroes both accumulators and overrides any operation issued in that cycle.
- R8: After reset both read ports show zero.
- R9: The effect of an issue at a rising edge is visible on the read ports right after that edge, and not before it.
- R10: In the default mode, 0x8000 times 0x8000 assigned reads 0x80000000, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of both accumulators |
| l0_valid | input | 1 | Lane 0 issue |
| l0_op | input | 2 | Lane 0 operation code |
| l0_src_a | input | 32 | Lane 0 first source word |
| l0_src_b | input | 32 | Lane 0 second source word |
| l0_a_hi | input | 1 | Lane 0 first operand half select |
| l0_b_hi | input | 1 | Lane 0 second operand half select |
| l1_valid | input | 1 | Lane 1 issue |
| l1_op | input | 2 | Lane 1 operation code |
| l1_src_a | input | 32 | Lane 1 first source word |
| l1_src_b | input | 32 | Lane 1 second source word |
| l1_a_hi | input | 1 | Lane 1 first operand half select |
| l1_b_hi | input | 1 | Lane 1 second operand half select |
| l1_mixed | input | 1 | Lane 1 signed-by-unsigned mode |
| acc0_word | output | 32 | Accumulator 0 bits [31:0] |
| acc1_word | output | 32 | Accumulator 1 bits [31:0] |

## Verification
Three kinds of event can land on the same edge: a clear, an issue on lane 0 and an issue on lane 1. The bench forces all three together in directed steps, and random traffic raises the clear at random beside random dual-lane issues. Each step is judged against a bench model in which the clear wins, and in which each lane otherwise updates from its own operands only. The 40-bit wrap is provoked by adding 0x80000000 twice and then subtracting it once, which checks the guard bits through the 32-bit window.

// File: rtl/dual_mac_pkg.sv
package dual_mac_pkg;
    parameter int HALF_W = 16;
    parameter int SRC_W  = 2 * HALF_W;
    parameter int ACC_W  = 40;
    parameter int NLANE  = 2;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_SET  = 2'b01,
        OP_ADD  = 2'b10,
        OP_SUB  = 2'b11
    } mac_op_e;
endpackage

// File: rtl/mac_half_pick.sv
module mac_half_pick #(
    parameter int HW = 16
) (
    input  logic [2*HW-1:0] word,
    input  logic            use_hi,
    output logic [HW-1:0]   half
);
    always_comb begin
        half = use_hi ? word[2*HW-1:HW] : word[HW-1:0];
    end
endmodule

// File: rtl/mac_product.sv
module mac_product #(
    parameter int HW = 16,
    parameter int AW = 40
) (
    input  logic [HW-1:0] opa,
    input  logic [HW-1:0] opb,
    input  logic          mixed,
    output logic [AW-1:0] prod
);
    localparam int PW = 2 * HW + 2;
    localparam int GUARD = AW - PW;

    logic signed [HW:0]   a_ext;
    logic signed [HW:0]   b_ext;
    logic signed [PW-1:0] raw;
    logic signed [PW-1:0] scaled;

    always_comb begin
        a_ext  = {opa[HW-1], opa};
        b_ext  = mixed ? {1'b0, opb} : {opb[HW-1], opb};
        raw    = PW'(a_ext * b_ext);
        scaled = mixed ? raw : (raw <<< 1);
        prod   = {{GUARD{scaled[PW-1]}}, scaled};
    end
endmodule

// File: rtl/mac_acc_next.sv
module mac_acc_next
    import dual_mac_pkg::*;
#(
    parameter int AW = 40
) (
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] prod,
    input  logic          valid,
    input  logic [1:0]    op,
    input  logic          clr,
    output logic [AW-1:0] acc_nx
);
    always_comb begin
        acc_nx = acc;
        if (clr) begin
            acc_nx = '0;
        end else if (valid) begin
            unique case (mac_op_e'(op))
                OP_SET:  acc_nx = prod;
                OP_ADD:  acc_nx = acc + prod;
                OP_SUB:  acc_nx = acc - prod;
                default: acc_nx = acc;
            endcase
        end
    end
endmodule

// File: rtl/dual_mac.sv
module dual_mac
    import dual_mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        l0_valid,
    input  logic [1:0]  l0_op,
    input  logic [31:0] l0_src_a,
    input  logic [31:0] l0_src_b,
    input  logic        l0_a_hi,
    input  logic        l0_b_hi,
    input  logic        l1_valid,
    input  logic [1:0]  l1_op,
    input  logic [31:0] l1_src_a,
    input  logic [31:0] l1_src_b,
    input  logic        l1_a_hi,
    input  logic        l1_b_hi,
    input  logic        l1_mixed,
    output logic [31:0] acc0_word,
    output logic [31:0] acc1_word
);
    localparam int RD_W = SRC_W;

    typedef struct packed {
        logic [NLANE-1:0][ACC_W-1:0] acc;
    } mac_state_t;

    mac_state_t state_d, state_q;

    logic [NLANE-1:0][SRC_W-1:0]  src_a, src_b;
    logic [NLANE-1:0]             sel_a, sel_b, vld, mix;
    logic [NLANE-1:0][1:0]        opc;
    logic [NLANE-1:0][HALF_W-1:0] opa, opb;
    logic [NLANE-1:0][ACC_W-1:0]  prod, acc_nx;

    always_comb begin
        src_a = {l1_src_a, l0_src_a};
        src_b = {l1_src_b, l0_src_b};
        sel_a = {l1_a_hi, l0_a_hi};
        sel_b = {l1_b_hi, l0_b_hi};
        vld   = {l1_valid, l0_valid};
        opc   = {l1_op, l0_op};
        mix   = {l1_mixed, 1'b0};
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        mac_half_pick #(.HW(HALF_W)) u_pick_a (
            .word(src_a[i]), .use_hi(sel_a[i]), .half(opa[i])
        );
        mac_half_pick #(.HW(HALF_W)) u_pick_b (
            .word(src_b[i]), .use_hi(sel_b[i]), .half(opb[i])
        );
        mac_product #(.HW(HALF_W), .AW(ACC_W)) u_prod (
            .opa(opa[i]), .opb(opb[i]), .mixed(mix[i]), .prod(prod[i])
        );
        mac_acc_next #(.AW(ACC_W)) u_next (
            .acc(state_q.acc[i]), .prod(prod[i]), .valid(vld[i]),
            .op(opc[i]), .clr(clr), .acc_nx(acc_nx[i])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NLANE; i++) begin
            state_d.acc[i] = acc_nx[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc0_word = state_q.acc[0][RD_W-1:0];
    assign acc1_word = state_q.acc[1][RD_W-1:0];
endmodule

// File: rtl/dual_mac_chk.sv
module dual_mac_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr,
    input logic        l0_valid,
    input logic [1:0]  l0_op,
    input logic [31:0] l0_src_a,
    input logic [31:0] l0_src_b,
    input logic        l0_a_hi,
    input logic        l0_b_hi,
    input logic        l1_valid,
    input logic [1:0]  l1_op,
    input logic [31:0] acc0_word,
    input logic [31:0] acc1_word
);
    logic [15:0] c_opa, c_opb;
    assign c_opa = l0_a_hi ? l0_src_a[31:16] : l0_src_a[15:0];
    assign c_opb = l0_b_hi ? l0_src_b[31:16] : l0_src_b[15:0];

    // R7
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc0_word == 32'h0 && acc1_word == 32'h0));

    // R6
    idle_lane0_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !l0_valid) |=> $stable(acc0_word));

    // R4
    hold_op_lane1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && l1_valid && l1_op == 2'b00) |=> $stable(acc1_word));

    // R2
    default_set_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && l0_valid && l0_op == 2'b01) |=> (acc0_word[0] == 1'b0));

    // R10
    neg_one_square_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && l0_valid && l0_op == 2'b01 && c_opa == 16'h8000 && c_opb == 16'h8000)
        |=> (acc0_word == 32'h80000000));
endmodule

bind dual_mac dual_mac_chk u_dual_mac_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .l0_valid(l0_valid), .l0_op(l0_op), .l0_src_a(l0_src_a), .l0_src_b(l0_src_b),
    .l0_a_hi(l0_a_hi), .l0_b_hi(l0_b_hi),
    .l1_valid(l1_valid), .l1_op(l1_op),
    .acc0_word(acc0_word), .acc1_word(acc1_word)
);

// File: tb/dual_mac_bench.sv
module dual_mac_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic l0_valid = 1'b0, l0_a_hi = 1'b0, l0_b_hi = 1'b0;
    logic l1_valid = 1'b0, l1_a_hi = 1'b0, l1_b_hi = 1'b0, l1_mixed = 1'b0;
    logic [1:0] l0_op = 2'b00, l1_op = 2'b00;
    logic [31:0] l0_src_a = '0, l0_src_b = '0, l1_src_a = '0, l1_src_b = '0;
    logic [31:0] acc0_word, acc1_word;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [39:0] m0 = '0, m1 = '0;

    always #2 clk = ~clk;

    dual_mac u_dual_mac (.*);

    function automatic logic [39:0] mprod(logic [15:0] a, logic [15:0] b, logic mx);
        longint sa, sb, p;
        sa = longint'($signed(a));
        sb = mx ? longint'({48'h0, b}) : longint'($signed(b));
        p = sa * sb;
        if (!mx) p = p * 2;
        return p[39:0];
    endfunction

    function automatic logic [39:0] mupd(logic [39:0] acc, logic [39:0] p, logic v, logic [1:0] op);
        if (!v) return acc;
        case (op)
            2'b01:   return p;
            2'b10:   return acc + p;
            2'b11:   return acc - p;
            default: return acc;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(string tag, logic c,
                         logic v0, logic [1:0] o0, logic [31:0] a0, logic [31:0] b0, logic ah0, logic bh0,
                         logic v1, logic [1:0] o1, logic [31:0] a1, logic [31:0] b1, logic ah1, logic bh1,
                         logic mx);
        logic [39:0] p0, p1;
        clr = c;
        l0_valid = v0; l0_op = o0; l0_src_a = a0; l0_src_b = b0; l0_a_hi = ah0; l0_b_hi = bh0;
        l1_valid = v1; l1_op = o1; l1_src_a = a1; l1_src_b = b1; l1_a_hi = ah1; l1_b_hi = bh1;
        l1_mixed = mx;
        p0 = mprod(ah0 ? a0[31:16] : a0[15:0], bh0 ? b0[31:16] : b0[15:0], 1'b0);
        p1 = mprod(ah1 ? a1[31:16] : a1[15:0], bh1 ? b1[31:16] : b1[15:0], mx);
        // R9: outputs unchanged before the edge
        #1;
        check({tag, " R9 lane0 pre-edge"}, acc0_word, m0[31:0]);
        @(posedge clk);
        if (c) begin
            m0 = '0; m1 = '0;
        end else begin
            m0 = mupd(m0, p0, v0, o0);
            m1 = mupd(m1, p1, v1, o1);
        end
        @(negedge clk);
        check({tag, " lane0"}, acc0_word, m0[31:0]);
        check({tag, " lane1"}, acc1_word, m1[31:0]);
        clr = 1'b0; l0_valid = 1'b0; l1_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset lane0", acc0_word, 32'h0);
        check("R8 reset lane1", acc1_word, 32'h0);

        // R3 R1: mixed assign on lane 1, low halves
        issue("R3 mixed set", 0, 0, 2'b00, 0, 0, 0, 0,
              1, 2'b01, 32'h123c5678, 32'h2345c789, 0, 0, 1);
        check("R3 literal", acc1_word, 32'h43658E38);
        // R2 R1 R6: default add on lane 0, high halves, lane 1 idle
        issue("R2 default add", 0, 1, 2'b10, 32'h34567c9a, 32'h456789c2, 1, 1,
              0, 2'b01, 0, 0, 0, 0, 0);
        check("R2 literal", acc0_word, 32'h1C607934);
        check("R6 idle lane1 kept", acc1_word, 32'h43658E38);
        // R5: subtract from zero wraps
        issue("R7 clear", 1, 0, 2'b00, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0);
        issue("R5 sub", 0, 0, 2'b00, 0, 0, 0, 0,
              1, 2'b11, 32'h123c5678, 32'h2345c789, 0, 0, 1);
        check("R5 literal", acc1_word, 32'hBC9A71C8);
        // R7: clear beside issues on both lanes
        issue("R7 clear wins", 1, 1, 2'b01, 32'h7fff7fff, 32'h7fff7fff, 0, 1,
              1, 2'b10, 32'h11112222, 32'h33334444, 1, 0, 1);
        check("R7 literal", acc0_word, 32'h0);
        // R10: -1 x -1 both lanes default mode
        issue("R10 neg one", 0, 1, 2'b01, 32'h80001234, 32'h00008000, 1, 0,
              1, 2'b10, 32'h80008000, 32'h80008000, 0, 1, 0);
        check("R10 literal", acc0_word, 32'h80000000);
        // R5: guard bits through the 32-bit window
        issue("R5 guard add", 0, 1, 2'b10, 32'h80000000, 32'h80000000, 1, 1,
              0, 2'b00, 0, 0, 0, 0, 0);
        check("R5 guard literal", acc0_word, 32'h0);
        issue("R5 guard sub", 0, 1, 2'b11, 32'h80000000, 32'h80000000, 1, 1,
              0, 2'b00, 0, 0, 0, 0, 0);
        check("R5 guard sub literal", acc0_word, 32'h80000000);
        // R4: hold code with valid high
        issue("R4 hold op", 0, 1, 2'b00, 32'h12345678, 32'h9abcdef0, 0, 0,
              1, 2'b00, 32'h12345678, 32'h9abcdef0, 1, 1, 1);
        // R3: mixed bit has no effect on lane 0 (lane 0 set with mixed high)
        issue("R3 lane0 default", 0, 1, 2'b01, 32'h0000ffff, 32'h0000ffff, 0, 0,
              0, 2'b00, 0, 0, 0, 0, 1);
        check("R3 lane0 literal", acc0_word, 32'h00000002);

        for (int k = 0; k < 400; k++) begin
            issue("R6 random", ($urandom % 16) == 0,
                  $urandom % 2 == 0, 2'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom),
                  $urandom % 2 == 0, 2'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom),
                  1'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule